// File: doc/BRIEF.md
# Dual-Line Caption Shift Capture

This block collects sliced caption data for two slice lines of a video field. A comparator delivers one data bit per data clock pulse. The block shifts that bit into a 16-bit capture word that belongs to the line currently being sliced, either the main line or the sub line. Each capture word fills from the least significant end, and it stops taking bits once it holds sixteen of them.

Software reads the four bytes through a 2-bit address select once the slicer has raised its interrupt. The same four bytes are also driven out as separate ports. A falling edge of the vertical sync separator clears both capture words and makes them ready for the next field.

The design uses two kinds of state machine. Each capture lane has the states `LN_EMPTY`, `LN_FILL` and `LN_DONE`, with these transitions:
- `LN_EMPTY` goes to `LN_FILL` on the first shift pulse.
- `LN_FILL` goes to `LN_DONE` on the sixteenth shift pulse.
- Any state goes back to `LN_EMPTY` on a clear.

The sync edge detector has the states `VS_WAIT_HIGH` and `VS_SEEN_HIGH`:
- `VS_WAIT_HIGH` goes to `VS_SEEN_HIGH` when the sync input is sampled high.
- `VS_SEEN_HIGH` goes back to `VS_WAIT_HIGH` when the sync input is sampled low. That same cycle is the falling-edge event that clears both lanes.

Top module: `caption_dual_capture`

## Requirements
- R1: After reset, all four bytes read as zero, both on the byte ports and through `rd_data`.
- R2: When `dclk_en` is high, `line_sel` is 0 and there is no clear, the main capture shifts one place toward its MSB and takes `slice_bit` into bit 0 at the next clock edge.
- R3: When `dclk_en` is high, `line_sel` is 1 and there is no clear, the sub capture shifts in the same way as in R2.
- R4: A shift pulse for one line leaves the other line's capture unchanged.
- R5: After sixteen pulses for one line, the first bit received sits in bit 15. The high byte carries bits 15..8 and the low byte carries bits 7..0.
- R6: Once a line holds sixteen bits, further pulses for that line have no effect until the next clear.
- R7: When `vsync_sep` is sampled low on a clock edge after it was sampled high, both captures become zero at that edge. Their bit counts restart, so a later run of sixteen pulses fills a line again.
- R8: When a shift pulse falls in the same cycle as the clear of R7, the clear wins and the bit is discarded.
- R9: A rising edge or a steady level of `vsync_sep` leaves both captures unchanged.
- R10: `rd_data` returns the following bytes for each value of `rd_addr`:
  - 0: main low byte
  - 1: main high byte
  - 2: sub low byte
  - 3: sub high byte

  Reading has no effect on the stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slice_bit | input | 1 | Comparator output bit |
| dclk_en | input | 1 | Data clock pulse, one cycle per bit |
| line_sel | input | 1 | Active slice line: 0 for main, 1 for sub |
| vsync_sep | input | 1 | Vertical sync separator level |
| rd_addr | input | 2 | Byte select for `rd_data` |
| rd_data | output | 8 | Selected byte |
| main_hi | output | 8 | Main capture bits 15..8 |
| main_lo | output | 8 | Main capture bits 7..0 |
| sub_hi | output | 8 | Sub capture bits 15..8 |
| sub_lo | output | 8 | Sub capture bits 7..0 |

## Verification
Two functions can fall on the same clock edge: a data clock pulse that would shift a bit, and the sync falling edge that clears the captures. The bench first fills the main line. It then drives `vsync_sep` low in the same cycle as a pulse that carries a 1 bit. The result passes only if the main capture reads zero afterwards, and if a fresh run of sixteen pulses then reproduces its pattern exactly, which shows that the bit count restarted as well.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        LN_EMPTY = 2'd0,
        LN_FILL  = 2'd1,
        LN_DONE  = 2'd2
    } lane_st_t;

    typedef enum logic {
        VS_WAIT_HIGH = 1'b0,
        VS_SEEN_HIGH = 1'b1
    } vs_st_t;
endpackage

// File: rtl/cap_vs_edge.sv
module cap_vs_edge
    import cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vs_i,
    output logic fall_o
);
    vs_st_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= VS_WAIT_HIGH;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d   = st_q;
        fall_o = 1'b0;
        unique case (st_q)
            VS_WAIT_HIGH: if (vs_i) st_d = VS_SEEN_HIGH;
            VS_SEEN_HIGH: if (!vs_i) begin
                st_d   = VS_WAIT_HIGH;
                fall_o = 1'b1;
            end
            default: st_d = VS_WAIT_HIGH;
        endcase
    end

    AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> (!vs_i && $past(vs_i))); // R9
endmodule

// File: rtl/cap_lane.sv
module cap_lane
    import cap_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              step_i,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    lane_st_t          st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [WORD_W-1:0] word_q, word_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= LN_EMPTY;
            cnt_q  <= '0;
            word_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            word_q <= word_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        word_d = word_q;
        unique case (st_q)
            LN_EMPTY: if (step_i) begin
                word_d = {word_q[WORD_W-2:0], bit_i};
                cnt_d  = CNT_W'(1);
                st_d   = LN_FILL;
            end
            LN_FILL: if (step_i) begin
                word_d = {word_q[WORD_W-2:0], bit_i};
                cnt_d  = cnt_q + CNT_W'(1);
                if (cnt_q == CNT_W'(WORD_W - 1)) st_d = LN_DONE;
            end
            LN_DONE: ;
            default: st_d = LN_EMPTY;
        endcase
        if (clr_i) begin
            st_d   = LN_EMPTY;
            cnt_d  = '0;
            word_d = '0;
        end
    end

    assign word_o = word_q;

    AST_LANE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (word_q == '0 && st_q == LN_EMPTY)); // R7
    AST_LANE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i && st_q != LN_DONE) |=>
        (word_q == {$past(word_q[WORD_W-2:0]), $past(bit_i)})); // R2
    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LN_DONE && !clr_i) |=> $stable(word_q)); // R6
    AST_LANE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !clr_i) |=> $stable(word_q)); // R4
    AST_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LN_DONE) |-> (cnt_q == CNT_W'(WORD_W))); // R5
endmodule

// File: rtl/cap_rd_mux.sv
module cap_rd_mux #(
    parameter int WORD_W = 16,
    parameter int NLINES = 2
) (
    input  logic [NLINES*WORD_W-1:0] words_i,
    input  logic [1:0]               addr_i,
    output logic [WORD_W/2-1:0]      data_o
);
    localparam int BYTE_W = WORD_W / 2;

    logic [WORD_W-1:0] sel_word;

    always_comb begin
        sel_word = words_i[addr_i[1]*WORD_W +: WORD_W];
        data_o   = addr_i[0] ? sel_word[WORD_W-1 -: BYTE_W] : sel_word[BYTE_W-1:0];
    end
endmodule

// File: rtl/caption_dual_capture.sv
module caption_dual_capture
    import cap_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slice_bit,
    input  logic                dclk_en,
    input  logic                line_sel,
    input  logic                vsync_sep,
    input  logic [1:0]          rd_addr,
    output logic [WORD_W/2-1:0] rd_data,
    output logic [WORD_W/2-1:0] main_hi,
    output logic [WORD_W/2-1:0] main_lo,
    output logic [WORD_W/2-1:0] sub_hi,
    output logic [WORD_W/2-1:0] sub_lo
);
    localparam int NLINES = 2;
    localparam int BYTE_W = WORD_W / 2;

    logic                     vs_fall;
    logic [NLINES*WORD_W-1:0] words;

    cap_vs_edge u_vs (
        .clk    (clk),
        .rst_n  (rst_n),
        .vs_i   (vsync_sep),
        .fall_o (vs_fall)
    );

    for (genvar g = 0; g < NLINES; g++) begin : g_lane
        logic step;
        assign step = dclk_en && (line_sel == 1'(g));
        cap_lane #(.WORD_W(WORD_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (vs_fall),
            .step_i (step),
            .bit_i  (slice_bit),
            .word_o (words[g*WORD_W +: WORD_W])
        );
    end

    cap_rd_mux #(.WORD_W(WORD_W), .NLINES(NLINES)) u_rd (
        .words_i (words),
        .addr_i  (rd_addr),
        .data_o  (rd_data)
    );

    assign main_lo = words[BYTE_W-1:0];
    assign main_hi = words[WORD_W-1 -: BYTE_W];
    assign sub_lo  = words[WORD_W +: BYTE_W];
    assign sub_hi  = words[2*WORD_W-1 -: BYTE_W];

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_fall && dclk_en) |=> (words == '0)); // R8
    AST_MAIN_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (dclk_en && line_sel && !vs_fall) |=> $stable(words[WORD_W-1:0])); // R4
    AST_SUB_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (dclk_en && !line_sel && !vs_fall) |=> $stable(words[2*WORD_W-1:WORD_W])); // R4
endmodule

// File: tb/sim_caption_dual_capture.sv
`timescale 1ns/1ps
module sim_caption_dual_capture;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slice_bit = 1'b0;
    logic       dclk_en = 1'b0;
    logic       line_sel = 1'b0;
    logic       vsync_sep = 1'b0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data, main_hi, main_lo, sub_hi, sub_lo;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    caption_dual_capture u0 (
        .clk(clk), .rst_n(rst_n), .slice_bit(slice_bit), .dclk_en(dclk_en),
        .line_sel(line_sel), .vsync_sep(vsync_sep), .rd_addr(rd_addr),
        .rd_data(rd_data), .main_hi(main_hi), .main_lo(main_lo),
        .sub_hi(sub_hi), .sub_lo(sub_lo)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%04h exp=%04h", req, got, exp);
        end
    endtask

    task automatic get_word(input logic ln, output logic [15:0] w);
        rd_addr = {ln, 1'b1}; #0.2;
        w[15:8] = rd_data;
        rd_addr = {ln, 1'b0}; #0.2;
        w[7:0]  = rd_data;
    endtask

    task automatic pulse(input logic ln, input logic b);
        @(negedge clk);
        dclk_en = 1'b1; line_sel = ln; slice_bit = b;
        @(negedge clk);
        dclk_en = 1'b0; slice_bit = 1'b0;
    endtask

    task automatic vs_fall();
        @(negedge clk); vsync_sep = 1'b1;
        @(negedge clk); vsync_sep = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog got=hung exp=done");
        finish_run();
    end

    initial begin
        logic [15:0] pats [4];
        logic [15:0] w, o, keep;
        pats[0] = 16'hA5C3; pats[1] = 16'hFFFF; pats[2] = 16'h8001; pats[3] = 16'h3C5A;

        repeat (3) @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a); #0.2;
            chk("R1 rd_data", {8'h0, rd_data}, 16'h0);
        end
        chk("R1 ports main", {main_hi, main_lo}, 16'h0);
        chk("R1 ports sub", {sub_hi, sub_lo}, 16'h0);
        rst_n = 1'b1;

        // R2 R3 R4 R5: partial and full fills, per line and pattern
        for (int ln = 0; ln < 2; ln++) begin
            for (int p = 0; p < 4; p++) begin
                vs_fall();
                get_word(1'(ln), w);
                chk("R7 cleared before fill", w, 16'h0);
                for (int k = 1; k <= 16; k++) begin
                    pulse(1'(ln), pats[p][16-k]);
                    get_word(1'(ln), w);
                    get_word(1'(1 - ln), o);
                    chk(ln == 0 ? "R2 main shift" : "R3 sub shift", w, pats[p] >> (16 - k));
                    chk("R4 other line unchanged", o, 16'h0);
                end
                chk("R5 byte ports", ln == 0 ? {main_hi, main_lo} : {sub_hi, sub_lo}, pats[p]);
                // R6: extra pulses ignored once full
                for (int x = 0; x < 3; x++) begin
                    pulse(1'(ln), ~pats[p][x]);
                    get_word(1'(ln), w);
                    chk("R6 hold when full", w, pats[p]);
                end
            end
        end

        // R10: address map and side-effect free reads; fill main and sub
        vs_fall();
        for (int k = 1; k <= 16; k++) pulse(1'b0, pats[0][16-k]);
        for (int k = 1; k <= 16; k++) pulse(1'b1, pats[3][16-k]);
        for (int rep = 0; rep < 2; rep++) begin
            rd_addr = 2'd0; #0.2; chk("R10 addr0 main low", {8'h0, rd_data}, {8'h0, pats[0][7:0]});
            rd_addr = 2'd1; #0.2; chk("R10 addr1 main high", {8'h0, rd_data}, {8'h0, pats[0][15:8]});
            rd_addr = 2'd2; #0.2; chk("R10 addr2 sub low", {8'h0, rd_data}, {8'h0, pats[3][7:0]});
            rd_addr = 2'd3; #0.2; chk("R10 addr3 sub high", {8'h0, rd_data}, {8'h0, pats[3][15:8]});
            @(negedge clk);
        end

        // R9: rising edge and steady levels do nothing
        @(negedge clk); vsync_sep = 1'b1;
        repeat (4) @(negedge clk);
        get_word(1'b0, w); chk("R9 main after rise", w, pats[0]);
        get_word(1'b1, w); chk("R9 sub after rise", w, pats[3]);
        vsync_sep = 1'b0;
        @(negedge clk);
        get_word(1'b0, w); chk("R7 main cleared on fall", w, 16'h0);
        get_word(1'b1, w); chk("R7 sub cleared on fall", w, 16'h0);
        keep = 16'h0;
        for (int k = 1; k <= 4; k++) pulse(1'b0, 1'b1);
        repeat (4) @(negedge clk);
        get_word(1'b0, w); chk("R9 steady low no clear", w, 16'h000F);

        // R8: clear and pulse in the same cycle
        vs_fall();
        for (int k = 1; k <= 16; k++) pulse(1'b0, pats[2][16-k]);
        @(negedge clk); vsync_sep = 1'b1;
        @(negedge clk); vsync_sep = 1'b0; dclk_en = 1'b1; line_sel = 1'b0; slice_bit = 1'b1;
        @(negedge clk); dclk_en = 1'b0; slice_bit = 1'b0;
        get_word(1'b0, w); chk("R8 clear wins over pulse", w, 16'h0);
        for (int k = 1; k <= 16; k++) pulse(1'b0, pats[0][16-k]);
        get_word(1'b0, w); chk("R7 R8 count restarted", w, pats[0]);
        chk("R5 main bytes after restart", {main_hi, main_lo}, pats[0]);

        finish_run();
    end
endmodule